// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns the bus address of an inbound PCI DMA transfer into a host memory address. Four programmable windows each carry a base, a size mask and a translated base. The first enabled window whose masked base matches the bus address decides how the address is mapped.

A window maps in one of two ways. In direct mode the low bus-address bits inside the window are merged with the translated base in a single step. In scatter-gather mode the block forms the address of a 64-bit page-table entry, reads that entry over a memory read request/response handshake, and builds the result from the page frame it holds plus the bus address's byte offset within an 8 KiB page.

Configuration comes in through a 64-bit write-only register port. A control register is kept alongside the windows and is visible on an output for neighbouring logic. Each translation ends with a one-cycle done strobe. A miss flag is raised with that strobe when no window claims the address.

Top module: `dma_window_xlate`

## Requirements
- R1: After reset, every window base, window mask and translated base is zero, `done`, `miss` and `mem_rd_valid` are low, `req_ready` is high, and `ctrl_reg` reads 0x0000_0021_0010_0000 (bits 20, 32 and 37 set).
- R2: A write with `csr_we` high stores all 64 bits of `csr_wdata` at the next clock edge. Index 0..3 selects window base 0..3, index 4..7 selects window mask 0..3, index 8..11 selects translated base 0..3, and index 12 selects the control register. Indices 13..15 change nothing.
- R3: Window base bit 0 enables the window, and a disabled window never hits. An enabled window hits when bus-address bits 31:20 and window-base bits 31:20 agree at every position where window-mask bits 31:20 are zero.
- R4: When more than one window hits, the lowest-numbered one is used.
- R5: Window base bit 1 low selects direct mode. Let K be mask bits 31:20 placed at bits 31:20, ORed with 0xFFFFF. The result is (bus address AND K) ORed with (translated base AND NOT K). `done` pulses in the cycle after the request is accepted.
- R6: Window base bit 1 high selects scatter-gather mode. Let M be mask bits 31:20 in place. The block requests one read at (translated base AND NOT((M >> 10) OR 0x3FF)) ORed with ((bus address AND (M OR 0xFE000)) >> 10).
- R7: In scatter-gather mode the result is ((entry with bit 0 cleared) << 12) ORed with bus-address bits 12:0. `done` pulses in the cycle after `mem_rsp_valid` is seen, with `miss` low.
- R8: Every memory address the block produces, both the entry address and the result, is cut to its low 34 bits.
- R9: If no enabled window hits, `done` and `miss` pulse together in the cycle after acceptance, `out_addr` is zero, and no memory read is issued.
- R10: `mem_rd_valid` and `mem_rd_addr` are held until a cycle with `mem_rd_ready` high. `req_ready` is low from acceptance of a scatter-gather request until its `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_idx | input | 4 | Register index |
| csr_wdata | input | 64 | Register write data |
| ctrl_reg | output | 64 | Control register contents |
| req_valid | input | 1 | Translation request |
| req_bus_addr | input | 32 | PCI bus address to translate |
| req_ready | output | 1 | Block idle, request accepted when high with req_valid |
| mem_rd_valid | output | 1 | Page-table entry read request |
| mem_rd_addr | output | 34 | Page-table entry address |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Page-table entry |
| done | output | 1 | Translation finished (one cycle) |
| miss | output | 1 | No window claimed the address, valid with done |
| out_addr | output | 34 | Translated host address, valid with done |

## Verification
The assertions assume that the memory side returns exactly one response for each accepted read, and only after the read is accepted. They also assume that `req_valid` is only treated as a request while `req_ready` is high. The bench's memory responder keeps to this: it raises `mem_rd_ready` after a random gap of zero to two cycles and returns the entry two cycles later. Requests are issued one at a time, each after the previous `done`. Register writes are made only between translations, so a window never changes while a fetch is outstanding.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
    localparam int WIN_HI    = 31;
    localparam int WIN_LO    = 20;
    localparam int PG_LO     = 13;
    localparam int PTE_SHIFT = 10;
    localparam int PG_SHIFT  = 12;
    localparam int EN_BIT    = 0;
    localparam int SG_BIT    = 1;
    localparam logic [63:0] CTRL_RST = (64'd1 << 20) | (64'd1 << 32) | (64'd2 << 36);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } xl_state_e;
endpackage

// File: rtl/xlate_csr_bank.sv
module xlate_csr_bank
    import xlate_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int DW      = 64,
    parameter int IDXW    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          csr_we,
    input  logic [IDXW-1:0]               csr_idx,
    input  logic [DW-1:0]                 csr_wdata,
    output logic [NUM_WIN-1:0][DW-1:0]    win_base,
    output logic [NUM_WIN-1:0][DW-1:0]    win_mask,
    output logic [NUM_WIN-1:0][DW-1:0]    win_tbase,
    output logic [DW-1:0]                 ctrl
);
    localparam int CTRL_IDX = 3 * NUM_WIN;

    typedef struct packed {
        logic [NUM_WIN-1:0][DW-1:0] base;
        logic [NUM_WIN-1:0][DW-1:0] mask;
        logic [NUM_WIN-1:0][DW-1:0] tbase;
        logic [DW-1:0]              ctrl;
    } bank_s;

    bank_s bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        if (csr_we) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (csr_idx == IDXW'(i))             bank_d.base[i]  = csr_wdata;
                if (csr_idx == IDXW'(NUM_WIN + i))   bank_d.mask[i]  = csr_wdata;
                if (csr_idx == IDXW'(2*NUM_WIN + i)) bank_d.tbase[i] = csr_wdata;
            end
            if (csr_idx == IDXW'(CTRL_IDX)) bank_d.ctrl = csr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q      <= '0;
            bank_q.ctrl <= DW'(CTRL_RST);
        end else begin
            bank_q <= bank_d;
        end
    end

    assign win_base  = bank_q.base;
    assign win_mask  = bank_q.mask;
    assign win_tbase = bank_q.tbase;
    assign ctrl      = bank_q.ctrl;

    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_we && csr_idx == IDXW'(CTRL_IDX)) |=> $stable(ctrl));
endmodule

// File: rtl/xlate_window_match.sv
module xlate_window_match
    import xlate_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int DW      = 64,
    parameter int BUS_AW  = 32,
    parameter int IW      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [BUS_AW-1:0]          bus_addr,
    input  logic [NUM_WIN-1:0][DW-1:0] win_base,
    input  logic [NUM_WIN-1:0][DW-1:0] win_mask,
    output logic                       hit_any,
    output logic [IW-1:0]              hit_idx
);
    localparam int FW = WIN_HI - WIN_LO + 1;

    logic [NUM_WIN-1:0] raw_hit;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        logic [FW-1:0] care;
        assign care       = ~win_mask[g][WIN_HI:WIN_LO];
        assign raw_hit[g] = win_base[g][EN_BIT] &&
            ((bus_addr[WIN_HI:WIN_LO] & care) == (win_base[g][WIN_HI:WIN_LO] & care));
    end

    always_comb begin
        hit_any = 1'b0;
        hit_idx = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (raw_hit[i]) begin
                hit_any = 1'b1;
                hit_idx = IW'(i);
            end
        end
    end

    p_lowest_win_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> (raw_hit[hit_idx] &&
            ((raw_hit & ((NUM_WIN'(1) << hit_idx) - NUM_WIN'(1))) == '0)));
    p_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any |-> win_base[hit_idx][EN_BIT]);
endmodule

// File: rtl/xlate_addr_calc.sv
module xlate_addr_calc
    import xlate_pkg::*;
#(
    parameter int DW     = 64,
    parameter int BUS_AW = 32,
    parameter int MEM_AW = 34
) (
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     win_mask,
    input  logic [DW-1:0]     win_tbase,
    input  logic [BUS_AW-1:0] saved_bus,
    input  logic [DW-1:0]     pte_data,
    output logic [MEM_AW-1:0] direct_addr,
    output logic [MEM_AW-1:0] pte_addr,
    output logic [MEM_AW-1:0] sg_addr
);
    localparam logic [DW-1:0] FIELD   = ((DW'(1) << (WIN_HI - WIN_LO + 1)) - DW'(1)) << WIN_LO;
    localparam logic [DW-1:0] SG_LOW  = ((DW'(1) << (WIN_LO - PG_LO)) - DW'(1)) << PG_LO;
    localparam logic [DW-1:0] DIR_LOW = (DW'(1) << WIN_LO) - DW'(1);
    localparam logic [DW-1:0] TB_LOW  = (DW'(1) << PTE_SHIFT) - DW'(1);
    localparam logic [DW-1:0] OFFSET  = (DW'(1) << PG_LO) - DW'(1);

    logic [DW-1:0] bus_w, saved_w, m_sel;
    logic [DW-1:0] sg_tmask, sg_bmask, dir_bmask;
    logic [DW-1:0] pte_full, dir_full, sg_full;

    always_comb begin
        bus_w     = DW'(bus_addr);
        saved_w   = DW'(saved_bus);
        m_sel     = win_mask & FIELD;
        sg_tmask  = ~((m_sel >> PTE_SHIFT) | TB_LOW);
        sg_bmask  = m_sel | SG_LOW;
        dir_bmask = m_sel | DIR_LOW;
        pte_full  = (win_tbase & sg_tmask) | ((bus_w & sg_bmask) >> PTE_SHIFT);
        dir_full  = (win_tbase & ~dir_bmask) | (bus_w & dir_bmask);
        sg_full   = ((pte_data & ~DW'(1)) << PG_SHIFT) | (saved_w & OFFSET);
        pte_addr    = pte_full[MEM_AW-1:0];
        direct_addr = dir_full[MEM_AW-1:0];
        sg_addr     = sg_full[MEM_AW-1:0];
    end
endmodule

// File: rtl/dma_window_xlate.sv
module dma_window_xlate
    import xlate_pkg::*;
#(
    parameter int NUM_WIN = 4,
    parameter int DW      = 64,
    parameter int BUS_AW  = 32,
    parameter int MEM_AW  = 34,
    parameter int IDXW    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_we,
    input  logic [IDXW-1:0]   csr_idx,
    input  logic [DW-1:0]     csr_wdata,
    output logic [DW-1:0]     ctrl_reg,
    input  logic              req_valid,
    input  logic [BUS_AW-1:0] req_bus_addr,
    output logic              req_ready,
    output logic              mem_rd_valid,
    output logic [MEM_AW-1:0] mem_rd_addr,
    input  logic              mem_rd_ready,
    input  logic              mem_rsp_valid,
    input  logic [DW-1:0]     mem_rsp_data,
    output logic              done,
    output logic              miss,
    output logic [MEM_AW-1:0] out_addr
);
    localparam int IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;

    typedef struct packed {
        xl_state_e         st;
        logic [BUS_AW-1:0] bus;
        logic [MEM_AW-1:0] rd_addr;
        logic [MEM_AW-1:0] res;
        logic              done;
        logic              miss;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic [NUM_WIN-1:0][DW-1:0] win_base, win_mask, win_tbase;
    logic                       hit_any;
    logic [IW-1:0]              hit_idx;
    logic [MEM_AW-1:0]          direct_addr, pte_addr, sg_addr;

    xlate_csr_bank #(.NUM_WIN(NUM_WIN), .DW(DW), .IDXW(IDXW)) u_bank (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_idx(csr_idx),
        .csr_wdata(csr_wdata), .win_base(win_base), .win_mask(win_mask),
        .win_tbase(win_tbase), .ctrl(ctrl_reg)
    );

    xlate_window_match #(.NUM_WIN(NUM_WIN), .DW(DW), .BUS_AW(BUS_AW), .IW(IW)) u_match (
        .clk(clk), .rst_n(rst_n), .bus_addr(req_bus_addr), .win_base(win_base),
        .win_mask(win_mask), .hit_any(hit_any), .hit_idx(hit_idx)
    );

    xlate_addr_calc #(.DW(DW), .BUS_AW(BUS_AW), .MEM_AW(MEM_AW)) u_calc (
        .bus_addr(req_bus_addr), .win_mask(win_mask[hit_idx]),
        .win_tbase(win_tbase[hit_idx]), .saved_bus(ctl_q.bus),
        .pte_data(mem_rsp_data), .direct_addr(direct_addr),
        .pte_addr(pte_addr), .sg_addr(sg_addr)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.miss = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.bus = req_bus_addr;
                    if (!hit_any) begin
                        ctl_d.done = 1'b1;
                        ctl_d.miss = 1'b1;
                        ctl_d.res  = '0;
                    end else if (win_base[hit_idx][SG_BIT]) begin
                        ctl_d.st      = ST_FETCH;
                        ctl_d.rd_addr = pte_addr;
                    end else begin
                        ctl_d.done = 1'b1;
                        ctl_d.res  = direct_addr;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_rd_ready) ctl_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    ctl_d.st   = ST_IDLE;
                    ctl_d.done = 1'b1;
                    ctl_d.res  = sg_addr;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign req_ready    = (ctl_q.st == ST_IDLE);
    assign mem_rd_valid = (ctl_q.st == ST_FETCH);
    assign mem_rd_addr  = ctl_q.rd_addr;
    assign done         = ctl_q.done;
    assign miss         = ctl_q.miss;
    assign out_addr     = ctl_q.res;

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !req_ready);
    p_miss_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> (done && out_addr == '0));
    p_miss_on_nohit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !hit_any) |=> (done && miss && !mem_rd_valid));
    p_sg_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_WAIT && mem_rsp_valid) |=> (done && !miss && req_ready));
endmodule

// File: tb/sim_dma_window_xlate.sv
module sim_dma_window_xlate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_we = 1'b0;
    logic [3:0]  csr_idx = '0;
    logic [63:0] csr_wdata = '0;
    logic [63:0] ctrl_reg;
    logic        req_valid = 1'b0;
    logic [31:0] req_bus_addr = '0;
    logic        req_ready;
    logic        mem_rd_valid;
    logic [33:0] mem_rd_addr;
    logic        mem_rd_ready = 1'b0;
    logic        mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done, miss;
    logic [33:0] out_addr;

    always #5 clk = ~clk;

    dma_window_xlate u0 (
        .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_idx(csr_idx),
        .csr_wdata(csr_wdata), .ctrl_reg(ctrl_reg), .req_valid(req_valid),
        .req_bus_addr(req_bus_addr), .req_ready(req_ready),
        .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
        .mem_rd_ready(mem_rd_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .miss(miss), .out_addr(out_addr)
    );

    typedef struct {
        bit          miss;
        bit          sg;
        logic [33:0] pte;
        logic [33:0] res;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [63:0] wb[4], wm[4], tb[4];
    int          n_chk = 0, n_bad = 0;
    bit          fetched = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] entry_of(input logic [33:0] a);
        return {30'h0, a} ^ 64'h0000_0001_2345_6789;
    endfunction

    // behavioural model built from the requirement text
    function automatic exp_t predict(input logic [31:0] ba, input string tag);
        exp_t        e;
        int          w;
        logic [63:0] m, bus64, full;
        e.tag = tag; e.miss = 1; e.sg = 0; e.pte = '0; e.res = '0;
        w = -1;
        bus64 = {32'h0, ba};
        for (int i = 0; i < 4; i++) begin
            if (w == -1 && wb[i][0] &&
                (((ba[31:20] ^ wb[i][31:20]) & ~wm[i][31:20]) == 12'h0)) w = i;
        end
        if (w >= 0) begin
            e.miss = 0;
            m = {32'h0, wm[w][31:20], 20'h0};
            if (wb[w][1]) begin
                e.sg = 1;
                full = (tb[w] & ~((m >> 10) | 64'h3FF)) | ((bus64 & (m | 64'hFE000)) >> 10);
                e.pte = full[33:0];
                full = ((entry_of(e.pte) & ~64'h1) << 12) | (bus64 & 64'h1FFF);
                e.res = full[33:0];
            end else begin
                full = (tb[w] & ~(m | 64'hFFFFF)) | (bus64 & (m | 64'hFFFFF));
                e.res = full[33:0];
            end
        end
        return e;
    endfunction

    task automatic csr_wr(input logic [3:0] idx, input logic [63:0] d);
        @(negedge clk);
        csr_we = 1; csr_idx = idx; csr_wdata = d;
        @(negedge clk);
        csr_we = 0;
        if (idx < 4) wb[idx] = d;
        else if (idx < 8) wm[idx-4] = d;
        else if (idx < 12) tb[idx-8] = d;
    endtask

    task automatic xlate(input logic [31:0] ba, input string tag);
        int guard;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        exp_q.push_back(predict(ba, tag));
        fetched = 0;
        req_valid = 1; req_bus_addr = ba;
        @(negedge clk);
        req_valid = 0;
        guard = 0;
        while (exp_q.size() != 0 && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        if (exp_q.size() != 0) begin
            chk(0, {tag, " R10 no done"}, 0, 1);
            exp_q.delete();
        end
    endtask

    // memory responder and fetch-address check (R6, R8, R10)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && mem_rd_valid) begin
                logic [33:0] cap;
                int gap;
                cap = mem_rd_addr;
                fetched = 1;
                if (exp_q.size() != 0)
                    chk(exp_q[0].sg && cap == exp_q[0].pte, {exp_q[0].tag, " R6 entry addr"},
                        64'(cap), 64'(exp_q[0].pte));
                else
                    chk(0, "R9 unexpected read", 64'(cap), 0);
                gap = $urandom_range(0, 2);
                for (int k = 0; k < gap; k++) begin
                    @(negedge clk);
                    chk(mem_rd_valid && mem_rd_addr == cap, "R10 request held", 64'(mem_rd_addr), 64'(cap));
                end
                mem_rd_ready = 1;
                @(negedge clk);
                mem_rd_ready = 0;
                @(negedge clk);
                chk(!req_ready, "R10 busy during fetch", 64'(req_ready), 0);
                @(negedge clk);
                mem_rsp_valid = 1;
                mem_rsp_data  = entry_of(cap);
                @(negedge clk);
                mem_rsp_valid = 0;
            end
        end
    end

    // per-clock comparison of the result stream (R3, R4, R5, R7, R8, R9)
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(0, "R10 stray done", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(miss == e.miss, {e.tag, " miss"}, 64'(miss), 64'(e.miss));
                chk(out_addr == e.res, {e.tag, " address"}, 64'(out_addr), 64'(e.res));
                chk(fetched == e.sg, {e.tag, " R9 fetch issued"}, 64'(fetched), 64'(e.sg));
            end
        end
    end

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        finish_run();
    end

    initial begin
        for (int i = 0; i < 4; i++) begin wb[i] = '0; wm[i] = '0; tb[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(ctrl_reg == 64'h0000_0021_0010_0000, "R1 ctrl reset", ctrl_reg, 64'h0000_0021_0010_0000);
        chk(!done && !miss && !mem_rd_valid && req_ready, "R1 idle outputs",
            {60'h0, done, miss, mem_rd_valid, req_ready}, 64'h1);
        xlate(32'h1234_5678, "R1 R9 all windows clear");

        // direct window 0: 256 MiB at 0x4000_0000
        csr_wr(4'd4, 64'h0000_0000_0FF0_0000);
        csr_wr(4'd8, 64'h0000_0002_8000_0000);
        csr_wr(4'd0, 64'h0000_0000_4000_0001);
        xlate(32'h4123_4567, "R5 direct hit");
        xlate(32'h5123_4567, "R3 R9 outside window");
        csr_wr(4'd0, 64'h0000_0000_4000_0000);
        xlate(32'h4123_4567, "R3 disabled window");
        csr_wr(4'd0, 64'h0000_0000_4000_0001);

        // overlapping windows 1 and 2, window 1 must win
        csr_wr(4'd5, 64'h0000_0000_0000_0000);
        csr_wr(4'd9, 64'h0000_0003_0000_0000);
        csr_wr(4'd1, 64'h0000_0000_8010_0001);
        csr_wr(4'd6, 64'h0000_0000_00F0_0000);
        csr_wr(4'd10, 64'h0000_0001_0000_0000);
        csr_wr(4'd2, 64'h0000_0000_8000_0001);
        xlate(32'h8012_3456, "R4 lowest window wins");
        xlate(32'h8052_3456, "R4 only window 2");

        // scatter-gather window 3 with upper tbase bits beyond 34
        csr_wr(4'd7, 64'h0000_0000_0030_0000);
        csr_wr(4'd11, 64'hFFFF_0000_1234_5000);
        csr_wr(4'd3, 64'h0000_0000_C000_0003);
        xlate(32'hC02A_BCDE, "R6 R7 R8 scatter-gather");
        xlate(32'hC031_2345, "R7 scatter-gather 2");
        csr_wr(4'd11, 64'hFFFF_FFFF_FFFF_FFFF);
        xlate(32'hC000_1FFF, "R8 truncation");

        // register index map
        csr_wr(4'd12, 64'h0000_0000_0000_ABCD);
        @(negedge clk);
        chk(ctrl_reg == 64'hABCD, "R2 ctrl write", ctrl_reg, 64'hABCD);
        @(negedge clk); csr_we = 1; csr_idx = 4'd13; csr_wdata = '1;
        @(negedge clk); csr_we = 0; csr_idx = 4'd15;
        @(negedge clk); csr_we = 1;
        @(negedge clk); csr_we = 0;
        chk(ctrl_reg == 64'hABCD, "R2 unused index ignored", ctrl_reg, 64'hABCD);
        xlate(32'h4123_4567, "R2 windows unchanged by unused index");

        // random sweep
        for (int n = 0; n < 60; n++) begin
            int k;
            logic [31:0] ba;
            if (n % 10 == 0) begin
                for (int i = 0; i < 4; i++) begin
                    csr_wr(4'(4 + i), {$urandom, $urandom});
                    csr_wr(4'(8 + i), {$urandom, $urandom});
                    csr_wr(4'(i), {$urandom, $urandom});
                end
            end
            k = $urandom_range(0, 3);
            ba = $urandom;
            if (n % 3 != 0) ba[31:20] = wb[k][31:20];
            xlate(ba, "R3 R5 R7 random");
        end
        finish_run();
    end
endmodule